// File: doc/BRIEF.md
# Polling Receiver Wake-Up Sequencer

This block produces the timing ticks of a low-power polling receiver and steps the receiver through its wake-up loop. A prescaler divides the crystal clock by 10 or by 14, picked by a ratio-select pin, to make a base tick. A second stage counts base ticks to make a function tick whose period is 8, 4, 2 or 1 base periods, picked by a two-bit rate-range field. The phase machine times a sleep phase and a settling phase in function ticks. It then waits in a bit-check phase until the demodulator reports a verdict.

A failed verdict sends the receiver back to sleep. A valid verdict moves it to a receive phase, and an end-of-message pulse ends that phase. The active indicator is high in every phase except sleep, and it gates the signal path. The ratio select, the rate range and both durations are sampled only when sleep is entered. The dividers restart at that same moment, so each sleep phase begins on a clean tick grid.

Top module: `poll_wake_seq`

## Requirements
- R1: `base_tick` pulses for one cycle every 10 crystal cycles when the captured ratio select is 0, and every 14 cycles when it is 1.
- R2: `func_tick` pulses on one `base_tick` out of every 8, 4, 2 or 1, for captured rate range 0, 1, 2 or 3, so its period is that multiple of the base period.
- R3: `phase` is encoded 0 = sleep, 1 = settle, 2 = bit-check, 3 = receive. The phase leaving sleep always goes to settle, and the phase leaving settle always goes to bit-check.
- R4: Sleep lasts exactly D x M x max(`sleep_len`,1) crystal cycles, where D is the prescale ratio and M the range multiple. `ic_active` is 0 throughout sleep.
- R5: Settle lasts exactly D x M x max(`start_len`,1) crystal cycles, and `ic_active` is 1 throughout.
- R6: Bit-check holds for as many cycles as needed until `chk_done`. `chk_done` with `chk_valid` = 0 enters sleep on the next cycle, and `chk_done` with `chk_valid` = 1 enters receive. `ic_active` is 1 in bit-check.
- R7: Receive holds until `msg_end` and then enters sleep on the next cycle. `chk_done` has no effect in receive, and `ic_active` is 1 there.
- R8: `msg_end` has no effect outside receive. `chk_done` has no effect in sleep or settle; a pulse there leaves the phase and the sleep length unchanged.
- R9: The ratio select, rate range, `sleep_len` and `start_len` are captured only on sleep entry. A change made during settle or bit-check leaves that phase's timing and the ticks unchanged until the next sleep.
- R10: While reset is asserted, `phase` is 0, and `ic_active`, `base_tick` and `func_tick` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_xtal | input | 1 | Crystal clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ratio_hi | input | 1 | Prescale select: 0 divides by 10, 1 by 14 |
| rate_rng | input | 2 | Range select for the function-tick multiple |
| sleep_len | input | 8 | Sleep length in function ticks (0 counts as 1) |
| start_len | input | 8 | Settle length in function ticks (0 counts as 1) |
| chk_done | input | 1 | Bit-check verdict strobe |
| chk_valid | input | 1 | Verdict: 1 valid transmitter found |
| msg_end | input | 1 | End-of-message strobe in receive |
| base_tick | output | 1 | Base tick pulse |
| func_tick | output | 1 | Function tick pulse |
| ic_active | output | 1 | High when not in sleep; enables signal path |
| phase | output | 2 | Current phase code |

## Verification
The loop is run with three configurations: ratio 10 with range 3 and lengths 2 and 1; ratio 14 with range 0 and zero lengths; and the mixed settings 10/range 1 and 14/range 2. The measured sleep and settle lengths and tick periods separate the two prescale ratios, the four range multiples and the zero-means-one rule. Settings are changed during settle and during bit-check to show that only sleep entry captures them. Stray verdict and end-of-message strobes are applied in every phase where they must do nothing, which separates the failed-verdict, valid-verdict and end-of-message exits.

// File: rtl/poll_pkg.sv
package poll_pkg;
  typedef enum logic [1:0] {
    PH_SLEEP = 2'd0,
    PH_START = 2'd1,
    PH_CHECK = 2'd2,
    PH_RECV  = 2'd3
  } phase_t;
endpackage

// File: rtl/poll_prescale.sv
module poll_prescale #(
  parameter int DIV_LO = 10,
  parameter int DIV_HI = 14
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic ratio_hi,
  output logic base_tick
);
  localparam int CW = $clog2(DIV_HI);

  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] lim;

  always_comb begin
    lim       = ratio_hi ? CW'(DIV_HI - 1) : CW'(DIV_LO - 1);
    base_tick = (cnt_q == lim);
    if (clr || base_tick) cnt_d = '0;
    else                  cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/poll_rate_scale.sv
module poll_rate_scale #(
  parameter int NRANGE = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      clr,
  input  logic                      base_tick,
  input  logic [$clog2(NRANGE)-1:0] rate_rng,
  output logic                      func_tick
);
  localparam int SW = (NRANGE > 1) ? NRANGE - 1 : 1;

  logic [SW-1:0] sc_q, sc_d;
  logic [SW-1:0] lim;
  int unsigned   sh;

  always_comb begin
    sh        = NRANGE - 1 - int'(rate_rng);
    lim       = SW'((32'd1 << sh) - 32'd1);
    func_tick = base_tick && (sc_q == lim);
    if (clr || func_tick) sc_d = '0;
    else if (base_tick)   sc_d = sc_q + 1'b1;
    else                  sc_d = sc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sc_q <= '0;
    else        sc_q <= sc_d;
  end
endmodule

// File: rtl/poll_phase_fsm.sv
module poll_phase_fsm
  import poll_pkg::*;
#(
  parameter int LW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          func_tick,
  input  logic [LW-1:0] sleep_len,
  input  logic [LW-1:0] start_len,
  input  logic          chk_done,
  input  logic          chk_valid,
  input  logic          msg_end,
  output phase_t        phase,
  output logic          load
);
  phase_t        ph_q, ph_d;
  logic [LW-1:0] tcnt_q, tcnt_d;
  logic [LW-1:0] len_sel;
  logic          first_q;
  logic          last;
  logic          timed;

  always_comb begin
    len_sel = (ph_q == PH_START) ? start_len : sleep_len;
    last    = (len_sel == '0) || (tcnt_q == len_sel - 1'b1);
    timed   = (ph_q == PH_SLEEP) || (ph_q == PH_START);
    ph_d    = ph_q;
    unique case (ph_q)
      PH_SLEEP: if (func_tick && last) ph_d = PH_START;
      PH_START: if (func_tick && last) ph_d = PH_CHECK;
      PH_CHECK: if (chk_done) ph_d = chk_valid ? PH_RECV : PH_SLEEP;
      PH_RECV:  if (msg_end) ph_d = PH_SLEEP;
      default:  ph_d = PH_SLEEP;
    endcase
    load = first_q || ((ph_q != PH_SLEEP) && (ph_d == PH_SLEEP));
    if (load || (ph_d != ph_q))  tcnt_d = '0;
    else if (func_tick && timed) tcnt_d = tcnt_q + 1'b1;
    else                         tcnt_d = tcnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q    <= PH_SLEEP;
      tcnt_q  <= '0;
      first_q <= 1'b1;
    end else begin
      ph_q    <= ph_d;
      tcnt_q  <= tcnt_d;
      first_q <= 1'b0;
    end
  end

  assign phase = ph_q;
endmodule

// File: rtl/poll_wake_seq.sv
module poll_wake_seq
  import poll_pkg::*;
#(
  parameter int DIV_LO = 10,
  parameter int DIV_HI = 14,
  parameter int NRANGE = 4,
  parameter int LW     = 8
) (
  input  logic                      clk_xtal,
  input  logic                      rst_n,
  input  logic                      ratio_hi,
  input  logic [$clog2(NRANGE)-1:0] rate_rng,
  input  logic [LW-1:0]             sleep_len,
  input  logic [LW-1:0]             start_len,
  input  logic                      chk_done,
  input  logic                      chk_valid,
  input  logic                      msg_end,
  output logic                      base_tick,
  output logic                      func_tick,
  output logic                      ic_active,
  output logic [1:0]                phase
);
  localparam int RW = $clog2(NRANGE);

  logic [1:0]    rst_sync;
  logic          rst_i;
  logic          load;
  logic          ratio_q;
  logic [RW-1:0] rate_q;
  logic [LW-1:0] slp_q, stt_q;
  phase_t        ph;

  always_ff @(posedge clk_xtal or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_i = rst_sync[1];

  always_ff @(posedge clk_xtal or negedge rst_i) begin
    if (!rst_i) begin
      ratio_q <= 1'b0;
      rate_q  <= '0;
      slp_q   <= '0;
      stt_q   <= '0;
    end else if (load) begin
      ratio_q <= ratio_hi;
      rate_q  <= rate_rng;
      slp_q   <= sleep_len;
      stt_q   <= start_len;
    end
  end

  poll_prescale #(.DIV_LO(DIV_LO), .DIV_HI(DIV_HI)) u_pre (
    .clk(clk_xtal), .rst_n(rst_i), .clr(load),
    .ratio_hi(ratio_q), .base_tick(base_tick)
  );

  poll_rate_scale #(.NRANGE(NRANGE)) u_rate (
    .clk(clk_xtal), .rst_n(rst_i), .clr(load),
    .base_tick(base_tick), .rate_rng(rate_q), .func_tick(func_tick)
  );

  poll_phase_fsm #(.LW(LW)) u_fsm (
    .clk(clk_xtal), .rst_n(rst_i), .func_tick(func_tick),
    .sleep_len(slp_q), .start_len(stt_q),
    .chk_done(chk_done), .chk_valid(chk_valid), .msg_end(msg_end),
    .phase(ph), .load(load)
  );

  assign phase     = ph;
  assign ic_active = (ph != PH_SLEEP);
endmodule

// File: rtl/poll_wake_seq_chk.sv
module poll_wake_seq_chk (
  input logic       clk_xtal,
  input logic       rst_n,
  input logic       chk_done,
  input logic       chk_valid,
  input logic       msg_end,
  input logic       base_tick,
  input logic       func_tick,
  input logic       ic_active,
  input logic [1:0] phase
);
  AST_SLEEP_TO_START: assert property (@(posedge clk_xtal) disable iff (!rst_n)
    ($past(phase) == 2'd0 && phase != 2'd0) |-> phase == 2'd1); // R3

  AST_START_TO_CHECK: assert property (@(posedge clk_xtal) disable iff (!rst_n)
    ($past(phase) == 2'd1 && phase != 2'd1) |-> phase == 2'd2); // R3

  AST_FUNC_ON_BASE: assert property (@(posedge clk_xtal) disable iff (!rst_n)
    func_tick |-> base_tick); // R2

  AST_TIMED_EXIT_ON_TICK: assert property (@(posedge clk_xtal) disable iff (!rst_n)
    ($past(phase) <= 2'd1 && phase != $past(phase)) |-> $past(func_tick)); // R4

  AST_CHECK_FAIL_SLEEP: assert property (@(posedge clk_xtal) disable iff (!rst_n)
    (phase == 2'd2 && chk_done && !chk_valid) |=> phase == 2'd0); // R6

  AST_CHECK_PASS_RECV: assert property (@(posedge clk_xtal) disable iff (!rst_n)
    (phase == 2'd2 && chk_done && chk_valid) |=> phase == 2'd3); // R6

  AST_RECV_HOLD: assert property (@(posedge clk_xtal) disable iff (!rst_n)
    (phase == 2'd3 && !msg_end) |=> phase == 2'd3); // R7

  AST_ACTIVE_OFF_IN_SLEEP: assert property (@(posedge clk_xtal) disable iff (!rst_n)
    $fell(ic_active) |-> phase == 2'd0); // R4
endmodule

bind poll_wake_seq poll_wake_seq_chk u_chk (
  .clk_xtal(clk_xtal), .rst_n(rst_n), .chk_done(chk_done),
  .chk_valid(chk_valid), .msg_end(msg_end), .base_tick(base_tick),
  .func_tick(func_tick), .ic_active(ic_active), .phase(phase)
);

// File: tb/poll_wake_seq_tb.sv
`timescale 1ns/1ps
module poll_wake_seq_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       ratio_hi;
  logic [1:0] rate_rng;
  logic [7:0] sleep_len, start_len;
  logic       chk_done, chk_valid, msg_end;
  logic       base_tick, func_tick, ic_active;
  logic [1:0] phase;

  int n_chk  = 0;
  int n_fail = 0;
  bit ended  = 0;

  always #5 clk = ~clk;

  poll_wake_seq u_dut (
    .clk_xtal(clk), .rst_n(rst_n), .ratio_hi(ratio_hi), .rate_rng(rate_rng),
    .sleep_len(sleep_len), .start_len(start_len), .chk_done(chk_done),
    .chk_valid(chk_valid), .msg_end(msg_end), .base_tick(base_tick),
    .func_tick(func_tick), .ic_active(ic_active), .phase(phase)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  task automatic wait_ph(input logic [1:0] p);
    int t = 0;
    while (phase != p && t < 20000) begin @(negedge clk); t++; end
    if (phase != p) check("R3 wait phase", phase, p);
  endtask

  task automatic measure(input logic [1:0] p, output int n);
    n = 0;
    while (phase == p && n < 20000) begin n++; @(negedge clk); end
  endtask

  task automatic base_period(output int n);
    int t = 0;
    while (!base_tick && t < 200) begin @(negedge clk); t++; end
    n = 0;
    do begin @(negedge clk); n++; end while (!base_tick && n < 200);
  endtask

  task automatic func_period(output int n);
    int t = 0;
    while (!func_tick && t < 2000) begin @(negedge clk); t++; end
    n = 0;
    do begin @(negedge clk); n++; end while (!func_tick && n < 2000);
  endtask

  task automatic pulse_done(input logic v);
    chk_done = 1'b1; chk_valid = v;
    @(negedge clk);
    chk_done = 1'b0; chk_valid = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; ratio_hi = 1'b0; rate_rng = 2'd3;
    sleep_len = 8'd2; start_len = 8'd1;
    chk_done = 1'b0; chk_valid = 1'b0; msg_end = 1'b0;
    repeat (3) @(negedge clk);
    check("R10 phase in reset", phase, 0);
    check("R10 ic_active in reset", ic_active, 0);
    check("R10 ticks in reset", {base_tick, func_tick}, 0);
    rst_n = 1'b1;
  endtask

  task automatic t_basic();
    int n;
    wait_ph(2'd1);
    check("R5 ic_active in settle", ic_active, 1);
    measure(2'd1, n);
    check("R5 settle length 10x1x1", n, 10);
    check("R3 settle goes to check", phase, 2);
    check("R6 ic_active in check", ic_active, 1);
    base_period(n);
    check("R1 base period ratio 10", n, 10);
    func_period(n);
    check("R2 func period range 3", n, 10);
    repeat (37) @(negedge clk);
    check("R6 check holds without verdict", phase, 2);
    pulse_done(1'b0);
    check("R6 failed verdict enters sleep", phase, 0);
    check("R4 ic_active low in sleep", ic_active, 0);
    measure(2'd0, n);
    check("R4 sleep length 10x1x2", n, 20);
    check("R3 sleep goes to settle", phase, 1);
  endtask

  task automatic t_deferred();
    int n;
    ratio_hi = 1'b1; rate_rng = 2'd0; sleep_len = 8'd0; start_len = 8'd0;
    measure(2'd1, n);
    check("R9 settle keeps old timing", n, 10);
    func_period(n);
    check("R9 func period keeps old range", n, 10);
    pulse_done(1'b0);
    measure(2'd0, n);
    check("R4 zero sleep length is one tick of 112", n, 112);
    rate_rng = 2'd3;
    measure(2'd1, n);
    check("R9 R5 settle zero length at 112", n, 112);
    base_period(n);
    check("R1 base period ratio 14", n, 14);
    func_period(n);
    check("R2 func period range 0", n, 112);
  endtask

  task automatic t_rates();
    int n;
    ratio_hi = 1'b0; rate_rng = 2'd1;
    wait_ph(2'd2);
    pulse_done(1'b0);
    measure(2'd0, n);
    check("R4 sleep at ratio 10 range 1", n, 40);
    wait_ph(2'd2);
    func_period(n);
    check("R2 func period range 1", n, 40);
    ratio_hi = 1'b1; rate_rng = 2'd2;
    pulse_done(1'b0);
    wait_ph(2'd2);
    func_period(n);
    check("R2 func period range 2", n, 28);
  endtask

  task automatic t_ignore();
    int n;
    msg_end = 1'b1;
    @(negedge clk);
    msg_end = 1'b0;
    check("R8 msg_end ignored in check", phase, 2);
    pulse_done(1'b0);
    chk_done = 1'b1; chk_valid = 1'b1; msg_end = 1'b1;
    @(negedge clk);
    chk_done = 1'b0; chk_valid = 1'b0; msg_end = 1'b0;
    measure(2'd0, n);
    check("R8 strobes ignored in sleep", n + 1, 28);
    chk_done = 1'b1; chk_valid = 1'b0;
    @(negedge clk);
    chk_done = 1'b0;
    check("R8 chk_done ignored in settle", phase, 1);
  endtask

  task automatic t_recv();
    int n;
    wait_ph(2'd2);
    pulse_done(1'b1);
    check("R6 valid verdict enters receive", phase, 3);
    check("R7 ic_active in receive", ic_active, 1);
    repeat (50) @(negedge clk);
    pulse_done(1'b0);
    check("R7 chk_done ignored in receive", phase, 3);
    msg_end = 1'b1;
    @(negedge clk);
    msg_end = 1'b0;
    check("R7 msg_end enters sleep", phase, 0);
    measure(2'd0, n);
    check("R9 sleep from receive restarts grid", n, 28);
  endtask

  initial begin
    t_reset();
    t_basic();
    t_deferred();
    t_rates();
    t_ignore();
    t_recv();
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finish_run();
  end
endmodule